// File: doc/BRIEF.md
# Nonvolatile Wiper Store/Restore Controller

This block owns the 6-bit code that positions a 64-step digital potentiometer wiper, together with a small emulated nonvolatile array. The array holds one saved wiper word and two read-only bytes that describe the end-to-end resistance tolerance. The saved word survives a logic reset, and only the separate power reset clears it. A bus front end, which is not part of this block, decodes commands and presents each one as a single-cycle strobe with data. The block carries out those commands, times the slow nonvolatile operations in clock cycles, and drives the wiper code.

After either reset the wiper is forced to midscale. After a programmable delay the block then reloads the saved word. An unprogrammed array holds midscale, so a fresh part settles at 0x20. Two mechanisms block nonvolatile writes. The first is a software protect bit. The second is a lockout window after reset, during which no rewrite is taken.

Top module: `nvw_ctrl`

## Requirements
- R1: While either reset is asserted, and for exactly PWRUP_CYC cycles after its release, `busy` is high and `wiper` is 0x20. When that interval ends, `wiper` takes the saved word and `busy` falls.
- R2: A power reset (`por_n` low) sets the saved word to 0x20. A logic reset (`rst_n` low) leaves the saved word unchanged, so the wiper reloads the previously saved value.
- R3: A `wiper_wr` strobe loads `wr_data[5:0]` into `wiper` at the next clock edge at any time, including while a nonvolatile write is in progress. The only exception is while a restore, including the power-up reload, is in progress.
- R4: An accepted `restore_req` holds `busy` high for RESTORE_CYC cycles and then copies the saved word into `wiper`. `wiper_wr` strobes during that interval are ignored.
- R5: An accepted `store_req` captures the wiper value present at acceptance. It then holds `busy` high for STORE_CYC cycles and writes the captured value into the saved word at the end.
- R6: An accepted `nv_wr` holds `busy` high for STORE_CYC cycles and then writes `wr_data[5:0]` into the saved word.
- R7: A `prot_wr` strobe sets the protect bit to `prot_val`. While the bit is 1, `store_req` and `nv_wr` are not accepted and `busy` stays low. If the bit is set while a nonvolatile write is pending, that write is dropped. `wiper_wr` is unaffected by the bit.
- R8: For the first LOCK_CYC clock edges after reset release, `store_req` and `nv_wr` are not accepted. A request sampled at edge LOCK_CYC+1 is accepted.
- R9: `store_req`, `nv_wr` and `restore_req` strobes that arrive while `busy` is high are ignored. They neither extend nor restart the operation in progress.
- R10: `rd_data` is selected by `rd_sel`: 0 gives the wiper, zero-extended; 1 gives the saved word, zero-extended; 2 gives the tolerance sign/integer byte (bit 7 is the sign, 1 meaning negative, and bits 6:0 are the integer percent); 3 gives the tolerance fraction byte (bit 7 weighs 2^-1 down to bit 0 at 2^-8).
- R11: Only one command is accepted when several arrive in the same idle cycle. The priority is restore, then store, then nv write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power reset, active low; clears the saved word |
| rst_n | input | 1 | Logic reset, active low; keeps the saved word |
| wiper_wr | input | 1 | Strobe: load wr_data into the wiper |
| nv_wr | input | 1 | Strobe: write wr_data into the saved word |
| store_req | input | 1 | Strobe: save the wiper into the saved word |
| restore_req | input | 1 | Strobe: reload the wiper from the saved word |
| prot_wr | input | 1 | Strobe: update the protect bit |
| prot_val | input | 1 | New protect bit value |
| wr_data | input | 6 | Data for wiper_wr and nv_wr |
| rd_sel | input | 2 | Readback select |
| rd_data | output | 8 | Readback data |
| wiper | output | 6 | Wiper code |
| busy | output | 1 | A store, write or restore is in progress |

## Verification
The bench builds the controller with STORE_CYC=5, PWRUP_CYC=3, RESTORE_CYC=4 and LOCK_CYC=12. At those values every busy window can be counted cycle by cycle, and the lockout edge can be hit exactly on its last blocked cycle and its first open one. The bench sweeps all 64 wiper codes through direct writes and readback. It also runs store and restore round trips over codes spread across the range. The short delays also leave room for collisions: strobes issued inside busy windows, protect changes while a write is pending, and simultaneous commands.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PWRUP   = 2'd1,
        ST_RESTORE = 2'd2,
        ST_PROGRAM = 2'd3
    } nvw_state_e;

    typedef enum logic [1:0] {
        RD_WIPER = 2'd0,
        RD_SAVED = 2'd1,
        RD_TOL_I = 2'd2,
        RD_TOL_F = 2'd3
    } nvw_rdsel_e;

endpackage

// File: rtl/nvw_lockout.sv
module nvw_lockout #(
    parameter int LEN = 5400
) (
    input  logic clk,
    input  logic rst_n,
    output logic active
);
    localparam int LW = $clog2(LEN + 2);

    logic [LW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= LW'(LEN);
        else        cnt_q <= cnt_d;
    end

    assign active = (cnt_q != '0);

endmodule

// File: rtl/nvw_nvarray.sv
module nvw_nvarray #(
    parameter int           CODE_W = 6,
    parameter logic [7:0]   TOL_HI = 8'h85,
    parameter logic [7:0]   TOL_LO = 8'h40
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              we,
    input  logic [CODE_W-1:0] wdata,
    output logic [CODE_W-1:0] word,
    output logic [7:0]        tol_int,
    output logic [7:0]        tol_frac
);
    localparam logic [CODE_W-1:0] BLANK = CODE_W'(1 << (CODE_W - 1));

    logic [CODE_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (we) word_d = wdata;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) word_q <= BLANK;
        else        word_q <= word_d;
    end

    assign word     = word_q;
    assign tol_int  = TOL_HI;
    assign tol_frac = TOL_LO;

endmodule

// File: rtl/nvw_ctrl.sv
module nvw_ctrl
    import nvw_pkg::*;
#(
    parameter int         CODE_W      = 6,
    parameter int         STORE_CYC   = 260000,
    parameter int         PWRUP_CYC   = 3000,
    parameter int         RESTORE_CYC = 3000,
    parameter int         LOCK_CYC    = 5400,
    parameter logic [7:0] TOL_HI      = 8'h85,
    parameter logic [7:0] TOL_LO      = 8'h40
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              wiper_wr,
    input  logic              nv_wr,
    input  logic              store_req,
    input  logic              restore_req,
    input  logic              prot_wr,
    input  logic              prot_val,
    input  logic [CODE_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [7:0]        rd_data,
    output logic [CODE_W-1:0] wiper,
    output logic              busy
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1 << (CODE_W - 1));
    localparam int MAXD_A = (STORE_CYC > RESTORE_CYC) ? STORE_CYC : RESTORE_CYC;
    localparam int MAXD   = (MAXD_A > PWRUP_CYC) ? MAXD_A : PWRUP_CYC;
    localparam int CW     = $clog2(MAXD + 1);

    typedef struct packed {
        nvw_state_e        st;
        logic [CW-1:0]     cnt;
        logic [CODE_W-1:0] wip;
        logic [CODE_W-1:0] pend;
        logic              prot;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              rst_all_n;
    logic              lock_active;
    logic              nv_we;
    logic [CODE_W-1:0] nv_word;
    logic [7:0]        tol_int, tol_frac;
    logic              nv_ok;
    logic              restoring;

    assign rst_all_n = por_n & rst_n;

    nvw_lockout #(.LEN(LOCK_CYC)) u_lock (
        .clk    (clk),
        .rst_n  (rst_all_n),
        .active (lock_active)
    );

    nvw_nvarray #(.CODE_W(CODE_W), .TOL_HI(TOL_HI), .TOL_LO(TOL_LO)) u_nv (
        .clk      (clk),
        .por_n    (por_n),
        .we       (nv_we),
        .wdata    (regs_q.pend),
        .word     (nv_word),
        .tol_int  (tol_int),
        .tol_frac (tol_frac)
    );

    always_comb begin
        regs_d    = regs_q;
        nv_we     = 1'b0;
        nv_ok     = !regs_q.prot && !lock_active;
        restoring = (regs_q.st == ST_PWRUP) || (regs_q.st == ST_RESTORE);

        if (prot_wr) regs_d.prot = prot_val;

        if (wiper_wr && !restoring) regs_d.wip = wr_data;

        case (regs_q.st)
            ST_IDLE: begin
                if (restore_req) begin
                    regs_d.st  = ST_RESTORE;
                    regs_d.cnt = CW'(RESTORE_CYC - 1);
                end else if (store_req && nv_ok) begin
                    regs_d.st   = ST_PROGRAM;
                    regs_d.cnt  = CW'(STORE_CYC - 1);
                    regs_d.pend = regs_q.wip;
                end else if (nv_wr && nv_ok) begin
                    regs_d.st   = ST_PROGRAM;
                    regs_d.cnt  = CW'(STORE_CYC - 1);
                    regs_d.pend = wr_data;
                end
            end
            ST_PWRUP, ST_RESTORE: begin
                if (regs_q.cnt == '0) begin
                    regs_d.wip = nv_word;
                    regs_d.st  = ST_IDLE;
                end else begin
                    regs_d.cnt = regs_q.cnt - 1'b1;
                end
            end
            ST_PROGRAM: begin
                if (regs_q.cnt == '0) begin
                    nv_we     = !regs_q.prot;
                    regs_d.st = ST_IDLE;
                end else begin
                    regs_d.cnt = regs_q.cnt - 1'b1;
                end
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_all_n) begin
        if (!rst_all_n) begin
            regs_q.st   <= ST_PWRUP;
            regs_q.cnt  <= CW'(PWRUP_CYC - 1);
            regs_q.wip  <= MID;
            regs_q.pend <= MID;
            regs_q.prot <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign wiper = regs_q.wip;
    assign busy  = (regs_q.st != ST_IDLE);

    always_comb begin
        case (nvw_rdsel_e'(rd_sel))
            RD_WIPER: rd_data = 8'(regs_q.wip);
            RD_SAVED: rd_data = 8'(nv_word);
            RD_TOL_I: rd_data = tol_int;
            default:  rd_data = tol_frac;
        endcase
    end

    // R1: the preset value is held for the whole power-up interval
    a_r1_preset_hold: assert property (@(posedge clk) disable iff (!rst_all_n)
        (regs_q.st == ST_PWRUP) |-> (wiper == MID));

    // R4: a finishing restore leaves the saved word on the wiper
    a_r4_restore_loads: assert property (@(posedge clk) disable iff (!rst_all_n)
        (regs_q.st == ST_RESTORE && regs_q.cnt == '0) |=> (wiper == $past(nv_word)));

    // R5: an unprotected program completion commits the pending value
    a_r5_store_commits: assert property (@(posedge clk) disable iff (!rst_all_n)
        (regs_q.st == ST_PROGRAM && regs_q.cnt == '0 && !regs_q.prot)
        |=> (nv_word == $past(regs_q.pend)));

    // R7: with protect set the saved word cannot change
    a_r7_prot_freeze: assert property (@(posedge clk) disable iff (!rst_all_n)
        regs_q.prot |=> $stable(nv_word));

    // R8: inside the lockout window the saved word cannot change
    a_r8_lock_freeze: assert property (@(posedge clk) disable iff (!rst_all_n)
        lock_active |=> $stable(nv_word));

    // R9: a running operation is never cut short by new requests
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_all_n)
        (busy && regs_q.cnt != '0) |=> busy);

endmodule

// File: tb/nvw_ctrl_test.sv
module nvw_ctrl_test;
    localparam int STORE_CYC   = 5;
    localparam int PWRUP_CYC   = 3;
    localparam int RESTORE_CYC = 4;
    localparam int LOCK_CYC    = 12;
    localparam int MID         = 32;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b0;
    logic       wiper_wr = 0, nv_wr = 0, store_req = 0, restore_req = 0;
    logic       prot_wr = 0, prot_val = 0;
    logic [5:0] wr_data = '0;
    logic [1:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic [5:0] wiper;
    logic       busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    nvw_ctrl #(
        .CODE_W(6), .STORE_CYC(STORE_CYC), .PWRUP_CYC(PWRUP_CYC),
        .RESTORE_CYC(RESTORE_CYC), .LOCK_CYC(LOCK_CYC),
        .TOL_HI(8'h85), .TOL_LO(8'h40)
    ) uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .wiper_wr(wiper_wr),
        .nv_wr(nv_wr), .store_req(store_req), .restore_req(restore_req),
        .prot_wr(prot_wr), .prot_val(prot_val), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .wiper(wiper), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic read_sel(input int sel, output int val);
        rd_sel = 2'(sel);
        #1 val = int'(rd_data);
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic put_wiper(input int c);
        wr_data = 6'(c); wiper_wr = 1; @(negedge clk); wiper_wr = 0;
    endtask

    task automatic put_nv(input int c);
        wr_data = 6'(c); nv_wr = 1; @(negedge clk); nv_wr = 0;
    endtask

    task automatic do_store;
        store_req = 1; @(negedge clk); store_req = 0;
    endtask

    task automatic do_restore;
        restore_req = 1; @(negedge clk); restore_req = 0;
    endtask

    task automatic set_prot(input bit v);
        prot_val = v; prot_wr = 1; @(negedge clk); prot_wr = 0;
    endtask

    task automatic do_reset(input bit pwr, input int exp_wiper);
        int n;
        if (pwr) por_n = 0; else rst_n = 0;
        repeat (2) @(negedge clk);
        por_n = 1; rst_n = 1;
        chk("R1 busy during power-up", int'(busy), 1);
        chk("R1 preset to midscale", int'(wiper), MID);
        wait_busy(n);
        chk("R1 power-up length", n, PWRUP_CYC);
        chk("R1 reload after power-up", int'(wiper), exp_wiper);
        repeat (LOCK_CYC) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n, v, s;
        repeat (3) @(negedge clk);
        // first power-up with exact lockout boundary (R1, R2, R8)
        por_n = 1; rst_n = 1;
        chk("R1 busy in reset release", int'(busy), 1);
        chk("R1 preset midscale", int'(wiper), MID);
        wait_busy(n);
        chk("R1 power-up length", n, PWRUP_CYC);
        chk("R2 unprogrammed wiper", int'(wiper), MID);
        read_sel(1, v);
        chk("R2 blank saved word", v, MID);
        repeat (LOCK_CYC - 1 - PWRUP_CYC) @(negedge clk);
        put_nv(6'h11);
        chk("R8 last locked edge busy", int'(busy), 0);
        read_sel(1, v);
        chk("R8 last locked edge saved", v, MID);
        put_nv(6'h11);
        wait_busy(n);
        chk("R8 first open edge accepted", n, STORE_CYC);
        read_sel(1, v);
        chk("R6 direct nv write", v, 6'h11);

        // R10 tolerance bytes
        read_sel(2, v); chk("R10 tolerance integer byte", v, 8'h85);
        read_sel(3, v); chk("R10 tolerance fraction byte", v, 8'h40);

        // R3 sweep of all wiper codes
        for (int c = 0; c < 64; c++) begin
            put_wiper(c);
            chk("R3 wiper write", int'(wiper), c);
            read_sel(0, v);
            chk("R10 wiper readback", v, c);
        end

        // R5 / R4 round trips
        for (int i = 0; i < 8; i++) begin
            int c;
            c = (i * 9 + 1) % 64;
            put_wiper(c);
            do_store;
            wait_busy(n);
            chk("R5 store busy length", n, STORE_CYC);
            read_sel(1, v);
            chk("R5 store saved word", v, c);
            put_wiper(63 - c);
            do_restore;
            wait_busy(n);
            chk("R4 restore busy length", n, RESTORE_CYC);
            chk("R4 restore wiper", int'(wiper), c);
        end

        // R4 wiper writes ignored during restore
        read_sel(1, s);
        put_wiper(6'h05);
        do_restore;
        put_wiper(6'h3A);
        chk("R4 write ignored during restore", int'(wiper), 6'h05);
        wait_busy(n);
        chk("R4 restore after ignored write", int'(wiper), s);

        // R3 wiper write during store, R5 captured value
        put_wiper(6'h2C);
        do_store;
        put_wiper(6'h07);
        chk("R3 write during store", int'(wiper), 6'h07);
        wait_busy(n);
        read_sel(1, v);
        chk("R5 captured at acceptance", v, 6'h2C);

        // R9 requests during busy ignored
        put_wiper(6'h19);
        do_store;
        put_nv(6'h01);
        wait_busy(n);
        chk("R9 busy not extended", n, STORE_CYC - 1);
        read_sel(1, v);
        chk("R9 nv write ignored while busy", v, 6'h19);
        @(negedge clk);
        chk("R9 no queued operation", int'(busy), 0);

        // R7 write protect
        set_prot(1);
        put_wiper(6'h33);
        chk("R7 wiper write under protect", int'(wiper), 6'h33);
        do_store;
        chk("R7 store refused busy", int'(busy), 0);
        put_nv(6'h0F);
        chk("R7 nv write refused busy", int'(busy), 0);
        read_sel(1, v);
        chk("R7 saved word unchanged", v, 6'h19);
        set_prot(0);
        put_nv(6'h3C);
        set_prot(1);
        wait_busy(n);
        read_sel(1, v);
        chk("R7 pending write dropped", v, 6'h19);
        set_prot(0);

        // R11 simultaneous commands
        put_wiper(6'h2E);
        wr_data = 6'h0A; restore_req = 1; store_req = 1; nv_wr = 1;
        @(negedge clk);
        restore_req = 0; store_req = 0; nv_wr = 0;
        wait_busy(n);
        chk("R11 restore wins length", n, RESTORE_CYC);
        chk("R11 restore wins wiper", int'(wiper), 6'h19);
        read_sel(1, v);
        chk("R11 saved untouched", v, 6'h19);
        wr_data = 6'h0B; store_req = 1; nv_wr = 1;
        @(negedge clk);
        store_req = 0; nv_wr = 0;
        wait_busy(n);
        read_sel(1, v);
        chk("R11 store beats nv write", v, 6'h19);

        // R2 logic reset keeps saved word, power reset clears it
        put_nv(6'h15);
        wait_busy(n);
        do_reset(1'b0, 6'h15);
        read_sel(1, v);
        chk("R2 logic reset keeps saved", v, 6'h15);
        do_reset(1'b1, MID);
        read_sel(1, v);
        chk("R2 power reset clears saved", v, MID);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule